// File: doc/BRIEF.md
# Windowed Interrupt Redirection Controller

This block gathers interrupt levels from sixteen device pins and turns qualifying assertions into delivery requests toward the processors. Each pin owns a 64-bit redirection entry that holds its mask, trigger type, delivery and destination modes, vector and destination ID. Software does not see the entries directly. It writes an index into a select register and then reads or writes the chosen 32-bit register through a data window. The whole register map sits behind that pair of bus offsets.

A pin acts only when its sampled level goes from low to high. An unmasked entry in physical destination mode with fixed delivery produces a request that carries the entry's vector and destination ID. A destination of 0xFF is flagged as a broadcast. A level-triggered pin that rises while masked is remembered as pending. When software later unmasks that entry, the pending mark is dropped, and if the pin is still high the request is raised then. Requests wait in a per-pin set. The lowest pin number is served first, through a valid/ready output that holds its contents until the consumer accepts them.

Top module: `irq_redirector`

## Requirements
- R1: A bus access takes effect only with all four byte enables set (bus_be_i = 4'hF) at offset 0x00 or 0x10. Any other access changes no state, and a read of it returns 0 on bus_rdata_o.
- R2: A write at offset 0x00 stores the 32-bit select, and a read at offset 0x00 returns it. An access at offset 0x10 reaches the register whose index is select bits 7:0.
- R3: Pin p's entry sits at index 0x10+2p (bits 31:0) and index 0x11+2p (bits 63:32). Each half reads back exactly what was written, and a write to one half leaves the other half unchanged.
- R4: Index 0x01 reads 0x0010_0011, which is the entry count 16 at bit 16 and the code 0x11 in the low byte. A write to index 0x00 keeps only data bits 31:24, and a read returns those bits in place with every other bit zero.
- R5: After reset every entry reads 0x0001_0000 in both halves, with mask bit 16 set, and dlv_valid_o is low. Raising any pin then causes no delivery.
- R6: Only a low-to-high change of a pin's sampled level can cause delivery. A pin held high or falling causes none. Suppose a pin is first seen high at clock edge k and no other request is ahead of it. Then dlv_valid_o is high after edge k+1, and not before.
- R7: A rising pin is delivered only when entry bit 16 (mask) = 0, bit 11 (destination mode) = 0 and bits 10:8 (delivery mode) = 000. The request carries entry bits 7:0 as the vector, bits 63:56 as the destination and the pin number. Any other setting produces no request.
- R8: dlv_bcast_o is high with a request exactly when its destination is 0xFF.
- R9: A pin that rises while its entry has bit 16 = 1 and bit 15 (level trigger) = 1 becomes pending. A masked pin with bit 15 = 0 is dropped, and unmasking it later delivers nothing.
- R10: A window write that leaves a pending entry with bit 16 = 0 clears the pending mark. If the pin is high at that moment, one delivery follows. If the pin is low, nothing is delivered.
- R11: Pending requests are issued lowest pin number first. dlv_vector_o, dlv_dest_o, dlv_bcast_o and dlv_pin_o hold steady while dlv_valid_o is high and dlv_ready_i is low. A pin that rises again while its previous request is still waiting produces one more delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register access strobe, one cycle per access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_be_i | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational during a read strobe, else 0 |
| pins_i | input | 16 | Interrupt pin levels, synchronous to clk_i |
| dlv_valid_o | output | 1 | Delivery request valid |
| dlv_ready_i | input | 1 | Consumer accepts the request |
| dlv_vector_o | output | 8 | Vector of the request |
| dlv_dest_o | output | 8 | Destination ID of the request |
| dlv_bcast_o | output | 1 | Request goes to all processors |
| dlv_pin_o | output | 4 | Pin that raised the request |

## Verification
The assertions assume that pins_i and the bus signals are already synchronous to clk_i and change only away from the active edge. They also assume that a read strobe is a plain level with no side effect, so the read-data checks may sample it in any cycle. The stimulus changes pins and bus inputs only on falling edges. It never writes a pin's entry in the same cycle that the pin rises, so the one ordering the design resolves arbitrarily is never exercised. The ready input is held low long enough to test the hold rule, and it is toggled pseudo-randomly in the free-running phase.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int unsigned HALF_W = 32;
  localparam int unsigned ENT_W  = 2 * HALF_W;

  typedef logic [ENT_W-1:0] rte_t;

  localparam rte_t RTE_RESET = 64'h0001_0000_0001_0000;

  // entry field positions
  localparam int unsigned RTE_VEC_LSB  = 0;
  localparam int unsigned RTE_VEC_W    = 8;
  localparam int unsigned RTE_MODE_LSB = 8;
  localparam int unsigned RTE_MODE_W   = 3;
  localparam int unsigned RTE_LOGICAL  = 11;
  localparam int unsigned RTE_LEVEL    = 15;
  localparam int unsigned RTE_MASK     = 16;
  localparam int unsigned RTE_DEST_LSB = 56;
  localparam int unsigned RTE_DEST_W   = 8;

  localparam logic [RTE_DEST_W-1:0] DEST_ALL = '1;

  typedef struct packed {
    logic [RTE_VEC_W-1:0]  vector;
    logic [RTE_DEST_W-1:0] dest;
    logic                  bcast;
  } dlv_t;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned SEL_OFS   = 'h00,
  parameter int unsigned WIN_OFS   = 'h10,
  parameter int unsigned TBL_BASE  = 'h10,
  parameter int unsigned ID_IDX    = 'h00,
  parameter int unsigned VER_IDX   = 'h01,
  parameter int unsigned VER_CODE  = 'h11,
  parameter int unsigned COUNT_LSB = 16,
  parameter int unsigned ID_LSB    = 24,
  parameter int unsigned ID_W      = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_valid_i,
  input  logic                       bus_write_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [HALF_W/8-1:0]        bus_be_i,
  input  logic [HALF_W-1:0]          bus_wdata_i,
  output logic [HALF_W-1:0]          bus_rdata_o,
  output logic [HALF_W-1:0]          win_sel_o,
  input  logic [NUM_PINS-1:0]        pin_level_i,
  input  logic [NUM_PINS-1:0]        pend_set_i,
  output logic [NUM_PINS-1:0]        fire_ok_o,
  output logic [NUM_PINS-1:0]        hold_ok_o,
  output logic [NUM_PINS-1:0]        replay_o,
  output dlv_t [NUM_PINS-1:0]        dlv_info_o
);

  localparam int unsigned IDX_W = 8;
  localparam logic [HALF_W-1:0] VER_WORD =
    (HALF_W'(NUM_PINS) << COUNT_LSB) | HALF_W'(VER_CODE);

  logic [HALF_W-1:0]   sel_q;
  logic [ID_W-1:0]     id_q;
  rte_t [NUM_PINS-1:0] ent_q;
  logic [NUM_PINS-1:0] pend_q;
  logic [NUM_PINS-1:0] pend_clr;

  logic             acc_ok, sel_hit, win_hit, win_wr, win_rd;
  logic [IDX_W-1:0] idx;

  assign acc_ok  = bus_valid_i && (bus_be_i == '1);
  assign sel_hit = acc_ok && (bus_addr_i == ADDR_W'(SEL_OFS));
  assign win_hit = acc_ok && (bus_addr_i == ADDR_W'(WIN_OFS));
  assign win_wr  = win_hit && bus_write_i;
  assign win_rd  = win_hit && !bus_write_i;
  assign idx     = sel_q[IDX_W-1:0];
  assign win_sel_o = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (sel_hit && bus_write_i) sel_q <= bus_wdata_i;
      if (win_wr && idx == IDX_W'(ID_IDX)) id_q <= bus_wdata_i[ID_LSB +: ID_W];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(TBL_BASE + 2 * p);
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(TBL_BASE + 2 * p + 1);

    logic wr_lo, wr_hi, touched;
    rte_t ent_new;

    assign wr_lo   = win_wr && (idx == LO_IDX);
    assign wr_hi   = win_wr && (idx == HI_IDX);
    assign touched = wr_lo || wr_hi;
    assign ent_new = {wr_hi ? bus_wdata_i : ent_q[p][ENT_W-1:HALF_W],
                      wr_lo ? bus_wdata_i : ent_q[p][HALF_W-1:0]};

    assign pend_clr[p] = touched && pend_q[p] && !ent_new[RTE_MASK];
    // replay as a fresh rise, judged against the entry being written
    assign replay_o[p] = pend_clr[p] && pin_level_i[p] && !ent_new[RTE_LOGICAL] &&
                         (ent_new[RTE_MODE_LSB +: RTE_MODE_W] == '0);

    assign fire_ok_o[p] = !ent_q[p][RTE_MASK] && !ent_q[p][RTE_LOGICAL] &&
                          (ent_q[p][RTE_MODE_LSB +: RTE_MODE_W] == '0);
    assign hold_ok_o[p] = ent_q[p][RTE_MASK] && ent_q[p][RTE_LEVEL];

    assign dlv_info_o[p].vector = ent_q[p][RTE_VEC_LSB +: RTE_VEC_W];
    assign dlv_info_o[p].dest   = ent_q[p][RTE_DEST_LSB +: RTE_DEST_W];
    assign dlv_info_o[p].bcast  = (ent_q[p][RTE_DEST_LSB +: RTE_DEST_W] == DEST_ALL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[p]  <= RTE_RESET;
        pend_q[p] <= 1'b0;
      end else begin
        if (touched) ent_q[p] <= ent_new;
        pend_q[p] <= (pend_q[p] && !pend_clr[p]) || pend_set_i[p];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_hit && !bus_write_i) begin
      bus_rdata_o = sel_q;
    end else if (win_rd) begin
      if (idx == IDX_W'(ID_IDX)) begin
        bus_rdata_o = HALF_W'(id_q) << ID_LSB;
      end else if (idx == IDX_W'(VER_IDX)) begin
        bus_rdata_o = VER_WORD;
      end else begin
        for (int p = 0; p < NUM_PINS; p++) begin
          if (idx == IDX_W'(TBL_BASE + 2 * p))     bus_rdata_o = ent_q[p][HALF_W-1:0];
          if (idx == IDX_W'(TBL_BASE + 2 * p + 1)) bus_rdata_o = ent_q[p][ENT_W-1:HALF_W];
        end
      end
    end
  end

endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] fire_ok_i,
  input  logic [NUM_PINS-1:0] hold_ok_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] fire_o,
  output logic [NUM_PINS-1:0] hold_o
);

  logic [NUM_PINS-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= pins_i;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise;
    assign rise      = pins_i[p] && !last_q[p];
    assign fire_o[p] = rise && fire_ok_i[p];
    assign hold_o[p] = rise && hold_ok_i[p];
  end

  assign level_o = last_q;

endmodule

// File: rtl/irq_dlv_queue.sv
module irq_dlv_queue
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] req_set_i,
  input  dlv_t [NUM_PINS-1:0] dlv_info_i,
  output logic                dlv_valid_o,
  input  logic                dlv_ready_i,
  output dlv_t                dlv_o,
  output logic [PIN_W-1:0]    dlv_pin_o
);

  logic [NUM_PINS-1:0] req_q, clr_mask;
  logic                out_v_q;
  dlv_t                out_q;
  logic [PIN_W-1:0]    out_pin_q;
  logic                found, take;
  logic [PIN_W-1:0]    pick;

  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_q[i]) begin
        found = 1'b1;
        pick  = PIN_W'(i);
      end
    end
  end

  assign take     = found && (!out_v_q || dlv_ready_i);
  assign clr_mask = take ? (NUM_PINS'(1) << pick) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      out_v_q   <= 1'b0;
      out_q     <= '0;
      out_pin_q <= '0;
    end else begin
      req_q <= (req_q & ~clr_mask) | req_set_i;
      if (take) begin
        out_v_q   <= 1'b1;
        out_q     <= dlv_info_i[pick];
        out_pin_q <= pick;
      end else if (dlv_ready_i) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign dlv_valid_o = out_v_q;
  assign dlv_o       = out_q;
  assign dlv_pin_o   = out_pin_q;

endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_redir_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [3:0]          bus_be_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic                dlv_valid_o,
  input  logic                dlv_ready_i,
  output logic [7:0]          dlv_vector_o,
  output logic [7:0]          dlv_dest_o,
  output logic                dlv_bcast_o,
  output logic [PIN_W-1:0]    dlv_pin_o
);

  logic [31:0]         win_sel;
  logic [NUM_PINS-1:0] level, fire, hold, replay, fire_ok, hold_ok;
  dlv_t [NUM_PINS-1:0] dlv_info;
  dlv_t                dlv;

  irq_regfile #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_be_i    (bus_be_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .win_sel_o   (win_sel),
    .pin_level_i (level),
    .pend_set_i  (hold),
    .fire_ok_o   (fire_ok),
    .hold_ok_o   (hold_ok),
    .replay_o    (replay),
    .dlv_info_o  (dlv_info)
  );

  irq_pin_detect #(
    .NUM_PINS (NUM_PINS)
  ) u_detect (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pins_i    (pins_i),
    .fire_ok_i (fire_ok),
    .hold_ok_i (hold_ok),
    .level_o   (level),
    .fire_o    (fire),
    .hold_o    (hold)
  );

  irq_dlv_queue #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
  ) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_set_i   (fire | replay),
    .dlv_info_i  (dlv_info),
    .dlv_valid_o (dlv_valid_o),
    .dlv_ready_i (dlv_ready_i),
    .dlv_o       (dlv),
    .dlv_pin_o   (dlv_pin_o)
  );

  assign dlv_vector_o = dlv.vector;
  assign dlv_dest_o   = dlv.dest;
  assign dlv_bcast_o  = dlv.bcast;

endmodule

// File: rtl/irq_redirector_chk.sv
module irq_redirector_chk #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned PIN_W    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [3:0]        bus_be_i,
  input logic [31:0]       bus_rdata_o,
  input logic [31:0]       win_sel_i,
  input logic              dlv_valid_o,
  input logic              dlv_ready_i,
  input logic [7:0]        dlv_vector_o,
  input logic [7:0]        dlv_dest_o,
  input logic              dlv_bcast_o,
  input logic [PIN_W-1:0]  dlv_pin_o
);

  localparam logic [31:0] VER_WORD = (32'(NUM_PINS) << 16) | 32'h11;

  logic rd_ok, bad_rd;
  assign rd_ok  = bus_valid_i && !bus_write_i && (bus_be_i == 4'hF);
  assign bad_rd = bus_valid_i && !bus_write_i &&
                  ((bus_be_i != 4'hF) ||
                   ((bus_addr_i != ADDR_W'('h00)) && (bus_addr_i != ADDR_W'('h10))));

  AST_DLV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o && !dlv_ready_i |=> dlv_valid_o && $stable(dlv_vector_o) &&
    $stable(dlv_dest_o) && $stable(dlv_bcast_o) && $stable(dlv_pin_o)); // R11

  AST_BCAST_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> (dlv_bcast_o == (dlv_dest_o == 8'hFF))); // R8

  AST_BAD_ACCESS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_rd |-> bus_rdata_o == 32'h0); // R1

  AST_SEL_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && bus_addr_i == ADDR_W'('h00) |-> bus_rdata_o == win_sel_i); // R2

  AST_VERSION_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ok && bus_addr_i == ADDR_W'('h10) && win_sel_i[7:0] == 8'h01
    |-> bus_rdata_o == VER_WORD); // R4

endmodule

bind irq_redirector irq_redirector_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .PIN_W    (PIN_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_addr_i   (bus_addr_i),
  .bus_be_i     (bus_be_i),
  .bus_rdata_o  (bus_rdata_o),
  .win_sel_i    (win_sel),
  .dlv_valid_o  (dlv_valid_o),
  .dlv_ready_i  (dlv_ready_i),
  .dlv_vector_o (dlv_vector_o),
  .dlv_dest_o   (dlv_dest_o),
  .dlv_bcast_o  (dlv_bcast_o),
  .dlv_pin_o    (dlv_pin_o)
);

// File: tb/tb_irq_redirector.sv
module tb_irq_redirector;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] pins = '0;
  logic        dlv_valid, dlv_ready = 1'b1, dlv_bcast;
  logic [7:0]  dlv_vector, dlv_dest;
  logic [3:0]  dlv_pin;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_redirector dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_be_i(bus_be), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pins_i(pins),
    .dlv_valid_o(dlv_valid), .dlv_ready_i(dlv_ready),
    .dlv_vector_o(dlv_vector), .dlv_dest_o(dlv_dest),
    .dlv_bcast_o(dlv_bcast), .dlv_pin_o(dlv_pin)
  );

  int    n_checks = 0, n_fail = 0;
  string tag = "R5";
  bit    done = 1'b0;
  int    hs_q[$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [63:0] m_ent [N];
  bit          m_last[N], m_pend[N], m_req[N];
  bit          m_ov, m_bc;
  logic [7:0]  m_vec, m_dest, m_id;
  int          m_pin;
  logic [31:0] m_sel;

  function automatic bit fires(logic [63:0] e);
    return !e[16] && !e[11] && (e[10:8] == 3'b000);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin
        m_ent[p] = 64'h0001_0000_0001_0000;
        m_last[p] = 0; m_pend[p] = 0; m_req[p] = 0;
      end
      m_ov = 0; m_bc = 0; m_vec = 0; m_dest = 0; m_id = 0; m_pin = 0; m_sel = 0;
    end else begin : step
      bit nreq[N], nset[N], nclr[N];
      int tp;
      for (int p = 0; p < N; p++) begin nreq[p] = 0; nset[p] = 0; nclr[p] = 0; end
      tp = -1;
      for (int p = N - 1; p >= 0; p--) if (m_req[p]) tp = p;
      if (tp >= 0 && (!m_ov || dlv_ready)) begin
        m_ov = 1; m_vec = m_ent[tp][7:0]; m_dest = m_ent[tp][63:56];
        m_bc = (m_ent[tp][63:56] == 8'hFF); m_pin = tp;
      end else begin
        tp = -1;
        if (dlv_ready) m_ov = 0;
      end
      for (int p = 0; p < N; p++)
        if (pins[p] && !m_last[p]) begin
          if (fires(m_ent[p])) nreq[p] = 1;
          else if (m_ent[p][16] && m_ent[p][15]) nset[p] = 1;
        end
      if (bus_valid && bus_write && bus_be == 4'hF) begin
        if (bus_addr == 8'h00) m_sel = bus_wdata;
        else if (bus_addr == 8'h10) begin
          int ix;
          ix = m_sel[7:0];
          if (ix == 0) m_id = bus_wdata[31:24];
          else if (ix >= 16 && ix < 16 + 2 * N) begin
            int p;
            logic [63:0] e;
            p = (ix - 16) / 2;
            e = m_ent[p];
            if (ix % 2) e[63:32] = bus_wdata; else e[31:0] = bus_wdata;
            m_ent[p] = e;
            if (m_pend[p] && !e[16]) begin
              nclr[p] = 1;
              if (m_last[p] && fires(e)) nreq[p] = 1;
            end
          end
        end
      end
      for (int p = 0; p < N; p++) begin
        if (p == tp) m_req[p] = 0;
        if (nreq[p]) m_req[p] = 1;
        if (nclr[p]) m_pend[p] = 0;
        if (nset[p]) m_pend[p] = 1;
        m_last[p] = pins[p];
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    int ix;
    if (!(bus_valid && !bus_write && bus_be == 4'hF)) return 32'h0;
    if (bus_addr == 8'h00) return m_sel;
    if (bus_addr != 8'h10) return 32'h0;
    ix = m_sel[7:0];
    if (ix == 0) return {m_id, 24'h0};
    if (ix == 1) return 32'h0010_0011;
    if (ix >= 16 && ix < 16 + 2 * N)
      return (ix % 2) ? m_ent[(ix - 16) / 2][63:32] : m_ent[(ix - 16) / 2][31:0];
    return 32'h0;
  endfunction

  // per-clock comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (rst_n && !done) begin
      chk(dlv_valid == m_ov, tag, "dlv_valid", dlv_valid, m_ov);
      if (m_ov) begin
        chk(dlv_vector == m_vec, tag, "dlv_vector", dlv_vector, m_vec);
        chk(dlv_dest == m_dest, tag, "dlv_dest", dlv_dest, m_dest);
        chk(dlv_bcast == m_bc, "R8", "dlv_bcast", dlv_bcast, m_bc);
        chk(dlv_pin == 4'(m_pin), tag, "dlv_pin", dlv_pin, m_pin);
      end
      chk(bus_rdata == exp_rd(), tag, "bus_rdata", bus_rdata, exp_rd());
    end
  end

  always @(posedge clk) if (rst_n && dlv_valid && dlv_ready) hs_q.push_back(int'(dlv_vector));

  // ---------------- stimulus helpers ----------------
  task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_be = 4'hF;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0; bus_be = 4'hF;
  endtask

  task automatic win_wr(logic [7:0] ix, logic [31:0] d);
    bus_wr(8'h00, {24'h0, ix});
    bus_wr(8'h10, d);
  endtask

  task automatic win_rd(logic [7:0] ix, output logic [31:0] d);
    bus_wr(8'h00, {24'h0, ix});
    bus_rd(8'h10, d);
  endtask

  task automatic set_entry(int p, logic [31:0] lo, logic [31:0] hi);
    win_wr(8'(16 + 2 * p + 1), hi);
    win_wr(8'(16 + 2 * p), lo);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(int p, bit v);
    @(negedge clk);
    pins[p] = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] lfsr;
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1;

    // reset state
    tag = "R5";
    chk(dlv_valid == 0, "R5", "valid after reset", dlv_valid, 0);
    win_rd(8'h10, rd); chk(rd == 32'h0001_0000, "R5", "pin0 low", rd, 32'h0001_0000);
    win_rd(8'h2F, rd); chk(rd == 32'h0001_0000, "R5", "pin15 high", rd, 32'h0001_0000);
    hs_q.delete();
    @(negedge clk) pins = '1;
    wait_cyc(5);
    chk(hs_q.size() == 0, "R5", "no delivery while masked", hs_q.size(), 0);
    @(negedge clk) pins = '0;
    wait_cyc(2);

    // bus decode
    tag = "R2";
    bus_wr(8'h00, 32'hABCD_0001);
    bus_rd(8'h00, rd); chk(rd == 32'hABCD_0001, "R2", "select readback", rd, 32'hABCD_0001);
    tag = "R4";
    bus_rd(8'h10, rd); chk(rd == 32'h0010_0011, "R4", "version via low byte of select", rd, 32'h0010_0011);
    tag = "R1";
    bus_wr(8'h00, 32'h0000_0000, 4'h3);
    bus_rd(8'h00, rd); chk(rd == 32'hABCD_0001, "R1", "partial write ignored", rd, 32'hABCD_0001);
    bus_wr(8'h04, 32'h0000_0000);
    bus_rd(8'h00, rd); chk(rd == 32'hABCD_0001, "R1", "bad offset write ignored", rd, 32'hABCD_0001);
    bus_rd(8'h04, rd); chk(rd == 0, "R1", "bad offset read", rd, 0);
    bus_rd(8'h00, rd, 4'h1); chk(rd == 0, "R1", "partial read", rd, 0);
    tag = "R4";
    win_wr(8'h00, 32'hFFFF_FFFF);
    win_rd(8'h00, rd); chk(rd == 32'hFF00_0000, "R4", "id field only", rd, 32'hFF00_0000);

    // entry mapping
    tag = "R3";
    set_entry(3, 32'h0000_0042, 32'h0500_0000);
    win_rd(8'h16, rd); chk(rd == 32'h0000_0042, "R3", "pin3 low half", rd, 32'h0000_0042);
    win_rd(8'h17, rd); chk(rd == 32'h0500_0000, "R3", "pin3 high half", rd, 32'h0500_0000);
    win_rd(8'h19, rd); chk(rd == 32'h0001_0000, "R3", "pin4 high untouched", rd, 32'h0001_0000);

    // delivery and latency
    tag = "R6";
    hs_q.delete();
    @(negedge clk) pins[3] = 1;
    @(negedge clk) chk(dlv_valid == 0, "R6", "valid one edge after rise", dlv_valid, 0);
    @(negedge clk) chk(dlv_valid == 1 && dlv_vector == 8'h42 && dlv_dest == 8'h05 && dlv_pin == 4'd3,
                       "R7", "request fields", {dlv_valid, dlv_vector, dlv_dest, dlv_pin}, {1'b1, 8'h42, 8'h05, 4'd3});
    wait_cyc(10);
    chk(hs_q.size() == 1, "R6", "held level delivers once", hs_q.size(), 1);
    pin(3, 0); wait_cyc(5);
    chk(hs_q.size() == 1, "R6", "falling delivers nothing", hs_q.size(), 1);

    // disqualified entries
    tag = "R7";
    set_entry(4, 32'h0000_0143, 32'h0100_0000);
    set_entry(9, 32'h0000_0844, 32'h0100_0000);
    hs_q.delete();
    pin(4, 1); pin(9, 1); wait_cyc(5);
    chk(hs_q.size() == 0, "R7", "non-fixed or logical dropped", hs_q.size(), 0);
    pin(4, 0); pin(9, 0);

    // broadcast
    tag = "R8";
    set_entry(5, 32'h0000_0055, 32'hFF00_0000);
    pin(5, 1);
    wait_cyc(2);
    chk(dlv_valid && dlv_bcast, "R8", "broadcast flag", dlv_bcast, 1);
    pin(5, 0); wait_cyc(3);

    // masked level replay
    tag = "R10";
    set_entry(6, 32'h0001_8050, 32'h0100_0000);
    hs_q.delete();
    pin(6, 1); wait_cyc(4);
    chk(hs_q.size() == 0, "R9", "masked level held back", hs_q.size(), 0);
    win_wr(8'h1C, 32'h0000_8050); wait_cyc(4);
    chk(hs_q.size() == 1 && hs_q[0] == 'h50, "R10", "unmask replays", hs_q.size(), 1);
    win_wr(8'h1C, 32'h0000_8050); wait_cyc(4);
    chk(hs_q.size() == 1, "R10", "pending cleared after replay", hs_q.size(), 1);
    pin(6, 0);
    set_entry(7, 32'h0001_8051, 32'h0100_0000);
    hs_q.delete();
    pin(7, 1); pin(7, 0);
    win_wr(8'h1E, 32'h0000_8051); wait_cyc(4);
    chk(hs_q.size() == 0, "R10", "unmask with pin low", hs_q.size(), 0);
    tag = "R9";
    set_entry(8, 32'h0001_0060, 32'h0100_0000);
    pin(8, 1); wait_cyc(2);
    win_wr(8'h20, 32'h0000_0060); wait_cyc(4);
    chk(hs_q.size() == 0, "R9", "masked edge dropped", hs_q.size(), 0);
    pin(8, 0);

    // ordering, hold, re-arm
    tag = "R11";
    set_entry(0, 32'h0000_0030, 32'h0100_0000);
    set_entry(1, 32'h0000_0031, 32'h0100_0000);
    set_entry(2, 32'h0000_0032, 32'h0100_0000);
    hs_q.delete();
    @(negedge clk) dlv_ready = 0;
    pin(2, 1); wait_cyc(3);
    @(negedge clk) begin pins[0] = 1; pins[1] = 1; end
    pin(2, 0); pin(2, 1);
    wait_cyc(6);
    chk(dlv_valid && dlv_pin == 4'd2, "R11", "held while not ready", dlv_pin, 2);
    @(negedge clk) dlv_ready = 1;
    wait_cyc(8);
    chk(hs_q.size() == 4, "R11", "delivery count", hs_q.size(), 4);
    if (hs_q.size() == 4) begin
      chk(hs_q[0] == 'h32, "R11", "order 0", hs_q[0], 'h32);
      chk(hs_q[1] == 'h30, "R11", "order 1", hs_q[1], 'h30);
      chk(hs_q[2] == 'h31, "R11", "order 2", hs_q[2], 'h31);
      chk(hs_q[3] == 'h32, "R11", "re-armed pin", hs_q[3], 'h32);
    end
    @(negedge clk) pins = '0;
    wait_cyc(3);

    // free-running mix against the reference
    tag = "R7";
    lfsr = 16'hACE1;
    for (int p = 0; p < N; p++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      set_entry(p, {15'h0, lfsr[0] & lfsr[1], lfsr[2], 3'h0, lfsr[3] & lfsr[4] & lfsr[5],
                    3'h0, lfsr[15:8]}, {lfsr[7:0] | {8{lfsr[6]}}, 24'h0});
    end
    tag = "R11";
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dlv_ready = lfsr[0] | lfsr[1];
      if (lfsr[2] & lfsr[3]) pins[lfsr[7:4]] = ~pins[lfsr[7:4]];
    end
    @(negedge clk) begin pins = '0; dlv_ready = 1; end
    wait_cyc(40);
    chk(dlv_valid == 0, "R11", "queue drains", dlv_valid, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule